// File: doc/BRIEF.md
# Reservation Station Bank with Shared Result Bus

This block puts five operation slots ("stations") in front of two execution units, an adder and a multiply/divide unit. Each station is a virtual copy of its unit. A dispatcher hands the block one operation at a time. The operation carries a 2-bit opcode and two operands, called sink and source. Each operand arrives either as a value, or as the 4-bit tag of the producer that will write it later.

Every cycle, all stations watch a single shared result bus. A waiting operand whose tag matches the tag on the bus latches the broadcast value, and its tag drops to zero. Tag zero always means "value present". A station whose two tags are both zero is handed to its unit when that unit is idle, and the station is freed at that moment. The units model fixed latencies and compute integer stand-ins for the arithmetic.

Three sources contend for the result bus: an external load-buffer input, the multiply/divide unit and the adder. A fixed-priority arbiter lets exactly one of them drive the bus in a cycle. The tag a unit broadcasts is the number of the station that held the operation, so later consumers can name it.

Top module: `rs_bank`

## Requirements
- R1: After reset every station is free, no result is on the bus, and a dispatch of either class is accepted (`disp_ready` high), offering station 1 for the adder class and station 4 for the multiply/divide class.
- R2: Opcode 00 (add) and 01 (subtract) go to the adder's stations, numbered 1 to 3. Opcode 10 (multiply) and 11 (divide) go to the multiply/divide unit's stations, numbered 4 and 5. The lowest-numbered free station of the class is taken, and `disp_id` shows its number while the handshake is offered.
- R3: An operand slot with a non-zero tag holds the station back. No result for that station reaches the bus while the tag is outstanding.
- R4: When the bus carries a valid tag equal to a waiting slot's tag, the slot takes the bus value and becomes ready. The operation then completes with that value.
- R5: Among ready stations of one unit, the lowest-numbered one starts first. A station becomes free again in the cycle it starts.
- R6: An operation dispatched with both operands present, into an idle unit, first appears on the bus in the cycle that begins L+1 rising edges after the dispatch edge. L is 2 for add and subtract, 3 for multiply and 12 for divide.
- R7: A unit's result carries the tag of its station. The value is a+b, a-b, or the low 32 bits of a*b, where a is sink and b is source. Divide gives a/b truncated, or all ones when b is zero.
- R8: The load-buffer input always wins the bus, then multiply/divide, then the adder. The value a load drives is visible on the bus in the same cycle. A unit that loses keeps its result unchanged and drives it in a later cycle.
- R9: When every station of the requested class is busy, `disp_ready` is low for that class. The offered operation is not stored, and the other class is unaffected.
- R10: If a dispatched operand's tag matches the bus in the dispatch cycle itself, the station stores the bus value instead of the tag.
- R11: A unit runs one operation at a time. The next ready station of that unit starts only after the previous result has left the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | Dispatch request |
| disp_ready | output | 1 | A station of the requested class is free |
| disp_op | input | 2 | Opcode: 00 add, 01 sub, 10 mul, 11 div |
| disp_sink_tag | input | 4 | Sink producer tag, 0 when value present |
| disp_sink_val | input | 32 | Sink value |
| disp_src_tag | input | 4 | Source producer tag, 0 when value present |
| disp_src_val | input | 32 | Source value |
| disp_id | output | 4 | Station number that would take the dispatch |
| ld_valid | input | 1 | Load buffer drives the bus this cycle |
| ld_tag | input | 4 | Load buffer tag (non-zero, not 1 to 5) |
| ld_val | input | 32 | Load buffer value |
| cdb_valid | output | 1 | Result bus carries a result |
| cdb_tag | output | 4 | Tag of the result on the bus |
| cdb_val | output | 32 | Value of the result on the bus |

## Verification
Two coincidences are provoked on purpose. In the first, a multiply and an add are timed to finish in the same cycle while a load is also driven. The bench expects the load on the bus that cycle, then the multiply, then the add one cycle later with its value unchanged. In the second, a dispatch is offered in the very cycle a load broadcasts the tag its sink waits on. The result must then arrive at the ready-operand latency with the broadcast value folded in, which shows the tag was never stored.

// File: rtl/rs_pkg.sv
package rs_pkg;
    localparam int DATA_W = 32;
    localparam int TAG_W  = 4;

    typedef logic [DATA_W-1:0] word_t;
    typedef logic [TAG_W-1:0]  tag_t;

    typedef enum logic [1:0] {
        OP_ADD = 2'b00,
        OP_SUB = 2'b01,
        OP_MUL = 2'b10,
        OP_DIV = 2'b11
    } op_e;

    typedef struct packed {
        logic  busy;
        op_e   op;
        tag_t  sink_tag;
        word_t sink_val;
        tag_t  src_tag;
        word_t src_val;
    } station_t;

    typedef struct packed {
        logic  valid;
        tag_t  tag;
        word_t val;
    } bus_t;
endpackage

// File: rtl/rs_station_set.sv
module rs_station_set import rs_pkg::*; #(
    parameter int N       = 3,
    parameter int BASE_ID = 1
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wr_en,
    input  op_e   wr_op,
    input  tag_t  wr_sink_tag,
    input  word_t wr_sink_val,
    input  tag_t  wr_src_tag,
    input  word_t wr_src_val,
    input  bus_t  cdb,
    input  logic  unit_free,
    output logic  has_free,
    output tag_t  free_id,
    output logic  iss_valid,
    output op_e   iss_op,
    output tag_t  iss_id,
    output word_t iss_a,
    output word_t iss_b
);
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

    station_t st_q [N];
    station_t st_d [N];

    logic             free_found;
    logic [IDX_W-1:0] free_idx;
    logic             rdy_found;
    logic [IDX_W-1:0] rdy_idx;

    function automatic logic bus_hit(tag_t t, bus_t b);
        return b.valid && (t != '0) && (t == b.tag);
    endfunction

    always_comb begin
        free_found = 1'b0;
        free_idx   = '0;
        rdy_found  = 1'b0;
        rdy_idx    = '0;
        for (int i = 0; i < N; i++) begin
            if (!st_q[i].busy && !free_found) begin
                free_found = 1'b1;
                free_idx   = IDX_W'(i);
            end
            if (st_q[i].busy && st_q[i].sink_tag == '0 &&
                st_q[i].src_tag == '0 && !rdy_found) begin
                rdy_found = 1'b1;
                rdy_idx   = IDX_W'(i);
            end
        end

        has_free  = free_found;
        free_id   = tag_t'(BASE_ID) + tag_t'(free_idx);
        iss_valid = rdy_found && unit_free;
        iss_op    = st_q[rdy_idx].op;
        iss_id    = tag_t'(BASE_ID) + tag_t'(rdy_idx);
        iss_a     = st_q[rdy_idx].sink_val;
        iss_b     = st_q[rdy_idx].src_val;

        st_d = st_q;
        for (int i = 0; i < N; i++) begin
            if (st_q[i].busy) begin
                if (bus_hit(st_q[i].sink_tag, cdb)) begin
                    st_d[i].sink_tag = '0;
                    st_d[i].sink_val = cdb.val;
                end
                if (bus_hit(st_q[i].src_tag, cdb)) begin
                    st_d[i].src_tag = '0;
                    st_d[i].src_val = cdb.val;
                end
            end
        end
        if (iss_valid) begin
            st_d[rdy_idx].busy = 1'b0;
        end
        if (wr_en && free_found) begin
            st_d[free_idx].busy = 1'b1;
            st_d[free_idx].op   = wr_op;
            if (bus_hit(wr_sink_tag, cdb)) begin
                st_d[free_idx].sink_tag = '0;
                st_d[free_idx].sink_val = cdb.val;
            end else begin
                st_d[free_idx].sink_tag = wr_sink_tag;
                st_d[free_idx].sink_val = wr_sink_val;
            end
            if (bus_hit(wr_src_tag, cdb)) begin
                st_d[free_idx].src_tag = '0;
                st_d[free_idx].src_val = cdb.val;
            end else begin
                st_d[free_idx].src_tag = wr_src_tag;
                st_d[free_idx].src_val = wr_src_val;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{default: '0};
        end else begin
            st_q <= st_d;
        end
    end

    // R10: a tag that matches the bus during dispatch is never stored
    a_r10_dispatch_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && free_found && cdb.valid && wr_sink_tag != '0 && cdb.tag == wr_sink_tag)
        |=> (st_q[$past(free_idx)].sink_tag == '0));

    // R5: the station handed to the unit is free afterwards
    a_r5_freed_on_issue: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid |=> !st_q[$past(rdy_idx)].busy);
endmodule

// File: rtl/rs_exec_unit.sv
module rs_exec_unit import rs_pkg::*; #(
    parameter int LAT_A = 2,
    parameter int LAT_B = 2
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  iss_valid,
    input  op_e   iss_op,
    input  tag_t  iss_id,
    input  word_t iss_a,
    input  word_t iss_b,
    input  logic  grant,
    output logic  free,
    output logic  req,
    output tag_t  res_tag,
    output word_t res_val
);
    localparam int LAT_MAX = (LAT_A > LAT_B) ? LAT_A : LAT_B;
    localparam int CNT_W   = $clog2(LAT_MAX + 1);

    typedef struct packed {
        logic             busy;
        logic             done;
        logic [CNT_W-1:0] cnt;
        tag_t             id;
        word_t            res;
    } unit_t;

    unit_t u_q, u_d;

    function automatic word_t compute(op_e op, word_t a, word_t b);
        case (op)
            OP_ADD:  return a + b;
            OP_SUB:  return a - b;
            OP_MUL:  return a * b;
            default: return (b == '0) ? '1 : a / b;
        endcase
    endfunction

    always_comb begin
        u_d = u_q;
        if (u_q.busy && !u_q.done) begin
            if (u_q.cnt == '0) u_d.done = 1'b1;
            else               u_d.cnt  = u_q.cnt - 1'b1;
        end
        if (u_q.done && grant) begin
            u_d.busy = 1'b0;
            u_d.done = 1'b0;
        end
        if (iss_valid) begin
            u_d.busy = 1'b1;
            u_d.done = 1'b0;
            u_d.cnt  = (iss_op == OP_DIV) ? CNT_W'(LAT_B - 1) : CNT_W'(LAT_A - 1);
            u_d.id   = iss_id;
            u_d.res  = compute(iss_op, iss_a, iss_b);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) u_q <= '0;
        else        u_q <= u_d;
    end

    assign free    = !u_q.busy;
    assign req     = u_q.done;
    assign res_tag = u_q.id;
    assign res_val = u_q.res;

    // R11: a new operation only enters an idle unit
    a_r11_one_at_a_time: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid |-> !u_q.busy);

    // R8: a result that loses the bus is held unchanged
    a_r8_hold_result: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !grant) |=> (req && $stable(res_val) && $stable(res_tag)));
endmodule

// File: rtl/rs_cdb_arb.sv
module rs_cdb_arb import rs_pkg::*; (
    input  logic  ld_valid,
    input  tag_t  ld_tag,
    input  word_t ld_val,
    input  logic  mul_req,
    input  tag_t  mul_tag,
    input  word_t mul_val,
    input  logic  add_req,
    input  tag_t  add_tag,
    input  word_t add_val,
    output bus_t  cdb,
    output logic  mul_grant,
    output logic  add_grant
);
    always_comb begin
        mul_grant = mul_req && !ld_valid;
        add_grant = add_req && !ld_valid && !mul_req;
        if (ld_valid) begin
            cdb = '{valid: 1'b1, tag: ld_tag, val: ld_val};
        end else if (mul_req) begin
            cdb = '{valid: 1'b1, tag: mul_tag, val: mul_val};
        end else if (add_req) begin
            cdb = '{valid: 1'b1, tag: add_tag, val: add_val};
        end else begin
            cdb = '0;
        end
    end
endmodule

// File: rtl/rs_bank.sv
module rs_bank import rs_pkg::*; #(
    parameter int N_ADD   = 3,
    parameter int N_MUL   = 2,
    parameter int ADD_LAT = 2,
    parameter int MUL_LAT = 3,
    parameter int DIV_LAT = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              disp_valid,
    output logic              disp_ready,
    input  logic [1:0]        disp_op,
    input  logic [TAG_W-1:0]  disp_sink_tag,
    input  logic [DATA_W-1:0] disp_sink_val,
    input  logic [TAG_W-1:0]  disp_src_tag,
    input  logic [DATA_W-1:0] disp_src_val,
    output logic [TAG_W-1:0]  disp_id,
    input  logic              ld_valid,
    input  logic [TAG_W-1:0]  ld_tag,
    input  logic [DATA_W-1:0] ld_val,
    output logic              cdb_valid,
    output logic [TAG_W-1:0]  cdb_tag,
    output logic [DATA_W-1:0] cdb_val
);
    localparam int ADD_BASE = 1;
    localparam int MUL_BASE = 1 + N_ADD;

    op_e   op;
    logic  to_mul;
    bus_t  cdb;
    logic  add_has_free, mul_has_free;
    tag_t  add_free_id, mul_free_id;
    logic  add_iss, mul_iss;
    op_e   add_iss_op, mul_iss_op;
    tag_t  add_iss_id, mul_iss_id;
    word_t add_a, add_b, mul_a, mul_b;
    logic  add_free, mul_free;
    logic  add_req, mul_req;
    tag_t  add_tag, mul_tag;
    word_t add_val, mul_val;
    logic  add_grant, mul_grant;

    assign op         = op_e'(disp_op);
    assign to_mul     = disp_op[1];
    assign disp_ready = to_mul ? mul_has_free : add_has_free;
    assign disp_id    = to_mul ? mul_free_id  : add_free_id;

    rs_station_set #(.N(N_ADD), .BASE_ID(ADD_BASE)) u_add_set (
        .clk, .rst_n,
        .wr_en(disp_valid && !to_mul), .wr_op(op),
        .wr_sink_tag(disp_sink_tag), .wr_sink_val(disp_sink_val),
        .wr_src_tag(disp_src_tag), .wr_src_val(disp_src_val),
        .cdb(cdb), .unit_free(add_free),
        .has_free(add_has_free), .free_id(add_free_id),
        .iss_valid(add_iss), .iss_op(add_iss_op), .iss_id(add_iss_id),
        .iss_a(add_a), .iss_b(add_b)
    );

    rs_station_set #(.N(N_MUL), .BASE_ID(MUL_BASE)) u_mul_set (
        .clk, .rst_n,
        .wr_en(disp_valid && to_mul), .wr_op(op),
        .wr_sink_tag(disp_sink_tag), .wr_sink_val(disp_sink_val),
        .wr_src_tag(disp_src_tag), .wr_src_val(disp_src_val),
        .cdb(cdb), .unit_free(mul_free),
        .has_free(mul_has_free), .free_id(mul_free_id),
        .iss_valid(mul_iss), .iss_op(mul_iss_op), .iss_id(mul_iss_id),
        .iss_a(mul_a), .iss_b(mul_b)
    );

    rs_exec_unit #(.LAT_A(ADD_LAT), .LAT_B(ADD_LAT)) u_adder (
        .clk, .rst_n,
        .iss_valid(add_iss), .iss_op(add_iss_op), .iss_id(add_iss_id),
        .iss_a(add_a), .iss_b(add_b), .grant(add_grant),
        .free(add_free), .req(add_req), .res_tag(add_tag), .res_val(add_val)
    );

    rs_exec_unit #(.LAT_A(MUL_LAT), .LAT_B(DIV_LAT)) u_muldiv (
        .clk, .rst_n,
        .iss_valid(mul_iss), .iss_op(mul_iss_op), .iss_id(mul_iss_id),
        .iss_a(mul_a), .iss_b(mul_b), .grant(mul_grant),
        .free(mul_free), .req(mul_req), .res_tag(mul_tag), .res_val(mul_val)
    );

    rs_cdb_arb u_arb (
        .ld_valid, .ld_tag, .ld_val,
        .mul_req, .mul_tag, .mul_val,
        .add_req, .add_tag, .add_val,
        .cdb(cdb), .mul_grant(mul_grant), .add_grant(add_grant)
    );

    assign cdb_valid = cdb.valid;
    assign cdb_tag   = cdb.tag;
    assign cdb_val   = cdb.val;

    // R8: at most one source owns the bus in a cycle
    a_r8_single_driver: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ld_valid, mul_grant, add_grant}));

    // R8: a load pre-empts both units
    a_r8_load_first: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid |-> (cdb_tag == ld_tag && !mul_grant && !add_grant));

    // R7: a unit result never carries the "value present" tag
    a_r7_nonzero_tag: assert property (@(posedge clk) disable iff (!rst_n)
        (mul_req || add_req) |-> (cdb_valid && cdb_tag != '0));
endmodule

// File: tb/tb_rs_bank.sv
module tb_rs_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        disp_valid = 1'b0;
    logic        disp_ready;
    logic [1:0]  disp_op = 2'b00;
    logic [3:0]  disp_sink_tag = '0;
    logic [31:0] disp_sink_val = '0;
    logic [3:0]  disp_src_tag = '0;
    logic [31:0] disp_src_val = '0;
    logic [3:0]  disp_id;
    logic        ld_valid = 1'b0;
    logic [3:0]  ld_tag = '0;
    logic [31:0] ld_val = '0;
    logic        cdb_valid;
    logic [3:0]  cdb_tag;
    logic [31:0] cdb_val;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    rs_bank dut (.*);

    localparam int NV = 6;
    localparam logic [1:0]  V_OP  [NV] = '{2'b00, 2'b01, 2'b10, 2'b11, 2'b11, 2'b01};
    localparam logic [31:0] V_A   [NV] = '{32'd5, 32'd20, 32'd6, 32'd100, 32'd9, 32'd3};
    localparam logic [31:0] V_B   [NV] = '{32'd7, 32'd3, 32'd7, 32'd7, 32'd0, 32'd5};
    localparam logic [31:0] V_EXP [NV] = '{32'd12, 32'd17, 32'd42, 32'd14, 32'hFFFF_FFFF, 32'hFFFF_FFFE};
    localparam int          V_N   [NV] = '{4, 4, 5, 14, 14, 4};
    localparam logic [3:0]  V_TAG [NV] = '{4'd1, 4'd1, 4'd4, 4'd4, 4'd4, 4'd1};

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic dispatch(input logic [1:0] op, input logic [3:0] st, input logic [31:0] sv,
                            input logic [3:0] rt, input logic [31:0] rv,
                            output logic rdy, output logic [3:0] id);
        @(negedge clk);
        disp_op = op; disp_sink_tag = st; disp_sink_val = sv;
        disp_src_tag = rt; disp_src_val = rv; disp_valid = 1'b1;
        #1 rdy = disp_ready; id = disp_id;
        @(posedge clk);
        #1 disp_valid = 1'b0;
    endtask

    task automatic load(input logic [3:0] t, input logic [31:0] v, input string req);
        @(negedge clk);
        ld_tag = t; ld_val = v; ld_valid = 1'b1;
        #1;
        check(cdb_valid && cdb_tag == t && cdb_val == v, req, "load on bus same cycle",
              {cdb_tag, cdb_val}, {t, v});
        @(posedge clk);
        #1 ld_valid = 1'b0;
    endtask

    task automatic wait_bus(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!cdb_valid && n < 40);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic       rdy;
        logic [3:0] id;
        int         n;
        int         ev_n   [6];
        logic [3:0] ev_tag [6];
        logic [31:0] ev_val [6];
        int         ev_cnt;

        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 / R2: reset state and station offers
        @(negedge clk);
        disp_op = 2'b00; #1;
        check(disp_ready == 1'b1, "R1", "adder ready after reset", disp_ready, 1);
        check(disp_id == 4'd1, "R2", "adder offers station 1", disp_id, 1);
        check(cdb_valid == 1'b0, "R1", "bus idle after reset", cdb_valid, 0);
        disp_op = 2'b11; #1;
        check(disp_ready == 1'b1, "R1", "muldiv ready after reset", disp_ready, 1);
        check(disp_id == 4'd4, "R2", "muldiv offers station 4", disp_id, 4);

        // R6 / R7: vector table, one independent op at a time
        for (int v = 0; v < NV; v++) begin
            dispatch(V_OP[v], 4'd0, V_A[v], 4'd0, V_B[v], rdy, id);
            check(rdy == 1'b1 && id == V_TAG[v], "R2", "vector dispatch station", id, V_TAG[v]);
            wait_bus(n);
            check(n == V_N[v], "R6", "latency", n, V_N[v]);
            check(cdb_tag == V_TAG[v], "R7", "result tag", cdb_tag, V_TAG[v]);
            check(cdb_val == V_EXP[v], "R7", "result value", cdb_val, V_EXP[v]);
            @(negedge clk);
        end

        // R3 / R4: waiting operand, then capture from a load
        dispatch(2'b00, 4'd7, 32'd0, 4'd0, 32'd100, rdy, id);
        check(rdy && id == 4'd1, "R2", "waiting add station", id, 1);
        begin
            bit seen = 1'b0;
            for (int k = 0; k < 6; k++) begin
                @(negedge clk);
                if (cdb_valid) seen = 1'b1;
            end
            check(!seen, "R3", "no result while tag outstanding", seen, 0);
        end
        load(4'd7, 32'd23, "R8");
        wait_bus(n);
        check(n == 4, "R4", "latency after capture", n, 4);
        check(cdb_tag == 4'd1 && cdb_val == 32'd123, "R4", "captured operand used",
              cdb_val, 123);
        @(negedge clk);

        // R9: fill the adder class, refuse a fourth
        for (int i = 0; i < 3; i++) begin
            dispatch(2'b00, 4'd9, 32'd0, 4'd0, 32'(i * 10), rdy, id);
            check(rdy && id == 4'(i + 1), "R2", "lowest free adder station", id, i + 1);
        end
        dispatch(2'b00, 4'd0, 32'd77, 4'd0, 32'd77, rdy, id);
        check(rdy == 1'b0, "R9", "adder class full refuses", rdy, 0);
        @(negedge clk);
        disp_op = 2'b10; #1;
        check(disp_ready == 1'b1 && disp_id == 4'd4, "R9", "muldiv unaffected by full adder",
              disp_ready, 1);
        for (int i = 0; i < 2; i++) begin
            dispatch(2'b10, 4'd11, 32'd0, 4'd0, 32'(i + 2), rdy, id);
            check(rdy && id == 4'(i + 4), "R2", "lowest free muldiv station", id, i + 4);
        end
        dispatch(2'b11, 4'd0, 32'd5, 4'd0, 32'd1, rdy, id);
        check(rdy == 1'b0, "R9", "muldiv class full refuses", rdy, 0);

        // R5 / R11: release all three adds at once
        load(4'd9, 32'd1000, "R8");
        ev_cnt = 0;
        for (int k = 1; k <= 16; k++) begin
            @(negedge clk);
            if (cdb_valid && ev_cnt < 6) begin
                ev_n[ev_cnt] = k; ev_tag[ev_cnt] = cdb_tag; ev_val[ev_cnt] = cdb_val;
                ev_cnt++;
            end
        end
        check(ev_cnt == 3, "R9", "refused add never ran", ev_cnt, 3);
        for (int i = 0; i < 3; i++) begin
            check(ev_tag[i] == 4'(i + 1), "R5", "lowest ready issues first", ev_tag[i], i + 1);
            check(ev_val[i] == 32'(1000 + i * 10), "R4", "adder value", ev_val[i], 1000 + i * 10);
            check(ev_n[i] == 4 + 4 * i, "R11", "one at a time spacing", ev_n[i], 4 + 4 * i);
        end

        load(4'd11, 32'd50, "R8");
        ev_cnt = 0;
        for (int k = 1; k <= 16; k++) begin
            @(negedge clk);
            if (cdb_valid && ev_cnt < 6) begin
                ev_n[ev_cnt] = k; ev_tag[ev_cnt] = cdb_tag; ev_val[ev_cnt] = cdb_val;
                ev_cnt++;
            end
        end
        check(ev_cnt == 2, "R9", "refused divide never ran", ev_cnt, 2);
        check(ev_tag[0] == 4'd4 && ev_val[0] == 32'd100, "R5", "station 4 first", ev_tag[0], 4);
        check(ev_tag[1] == 4'd5 && ev_val[1] == 32'd150, "R5", "station 5 second", ev_tag[1], 5);
        check(ev_n[0] == 5 && ev_n[1] == 10, "R11", "muldiv spacing", ev_n[1], 10);

        // R8: load, multiply and add all want the bus in one cycle
        dispatch(2'b10, 4'd0, 32'd8, 4'd0, 32'd9, rdy, id);
        dispatch(2'b00, 4'd0, 32'd30, 4'd0, 32'd4, rdy, id);
        @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        check(cdb_valid == 1'b0, "R8", "bus idle before collision", cdb_valid, 0);
        @(negedge clk);
        ld_tag = 4'd6; ld_val = 32'hABCD; ld_valid = 1'b1;
        #1;
        check(cdb_valid && cdb_tag == 4'd6 && cdb_val == 32'hABCD, "R8", "load wins",
              cdb_tag, 6);
        @(posedge clk);
        #1 ld_valid = 1'b0;
        @(negedge clk);
        check(cdb_valid && cdb_tag == 4'd4 && cdb_val == 32'd72, "R8", "multiply beats add",
              cdb_tag, 4);
        @(negedge clk);
        check(cdb_valid && cdb_tag == 4'd1 && cdb_val == 32'd34, "R8", "held add result",
              {cdb_tag, cdb_val}, {4'd1, 32'd34});
        @(negedge clk);
        check(cdb_valid == 1'b0, "R8", "bus idle after drain", cdb_valid, 0);

        // R10: dispatch in the same cycle as the matching broadcast
        ld_tag = 4'd10; ld_val = 32'd500; ld_valid = 1'b1;
        dispatch(2'b01, 4'd10, 32'd0, 4'd0, 32'd1, rdy, id);
        ld_valid = 1'b0;
        check(rdy && id == 4'd1, "R10", "same-cycle dispatch accepted", id, 1);
        wait_bus(n);
        check(n == 4, "R10", "ready-operand latency", n, 4);
        check(cdb_tag == 4'd1 && cdb_val == 32'd499, "R10", "broadcast value captured",
              cdb_val, 499);

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule